// File: doc/BRIEF.md
# Dual-Master Packet Buffer Strobe Generator

This block drives the chip selects and timing strobes for a shared packet buffer and for a small register port of a network controller. Two masters use the buffer, one at a time. The host reaches it through a decoded board window. The network controller reaches it with its own word-addressed read and write strobes. An external arbiter grants the bus, and the block only sees its verdict on `ctl_owns`. The buffer is split into banks of 16-bit words, and one host address bit picks the bank. Each bank has its own chip select, so one physical buffer can be built from narrower parts.

Host reads are purely combinational: board select, read direction and the upper or lower data strobe together open the selected bank or the register port. Host writes are timed by a small counter. On the first clock edge after a qualified write strobe, a write pulse opens and is held for a fixed number of cycles. The pulse is then closed by an end-of-cycle signal, which the block raises while the host still holds its strobes. The host removes its strobes one clock after it sees end-of-cycle, so the data outlives the write enable. When the controller owns the bus, host inputs have no effect and the controller's strobes time the buffer directly.

Every pin here is plain control. No data moves through the block, so there is no valid/ready stream and no back-pressure. The host is held off only through the end-of-cycle signal, because it waits for that signal before ending a write.

Top module: `pkt_mem_strobe_gen`

## Requirements
- R1: A host read (`host_sel`=1, `host_rd`=1, `host_uds` or `host_lds` high) to a byte offset with bit HOST_AW-1 set asserts `mem_oe` and exactly one bit of `mem_cs`. The bit index is taken from the BANK_BITS address bits directly below (bit 14 with the defaults). `mem_addr` carries host address bits [WORD_AW:1].
- R2: During a host write pulse to the buffer, `mem_we_ub` follows `host_uds` and `mem_we_lb` follows `host_lds`, so each byte lane is written independently. Outside the pulse, no host write enable is asserted.
- R3: A host write (`host_rd`=0) opens its pulse on the first clock edge after the strobe qualifies. The pulse lasts exactly WR_CYCLES cycles. After that, `end_cyc` goes high with no write enable active, and stays high until the host drops its strobes or its select.
- R4: The register port takes the two 16-bit words at byte offsets 4*REG_IDX and 4*REG_IDX+2, with bit HOST_AW-1 clear. A host access there asserts `reg_cs`, and `reg_sel_data` equals host address bit 1. `reg_oe` is asserted on reads, and `reg_we` only during the write pulse.
- R5: `reg_cs` and `mem_cs` are never active together. Neither is asserted when `host_sel` is low, when both data strobes are low, or at a host offset outside the buffer and the register port.
- R6: While `ctl_owns`=1, host inputs are ignored. No register strobe fires, no write pulse starts and `end_cyc` stays low. A pulse that is already running is abandoned.
- R7: While `ctl_owns`=1 and exactly one of `ctl_rd` and `ctl_wr` is high, the bank named by the top BANK_BITS bits of `ctl_addr` is selected and `mem_addr` carries the remaining bits. `ctl_rd` drives `mem_oe`, and `ctl_wr` drives both byte-lane write enables.
- R8: A controller cycle with `ctl_rd` and `ctl_wr` both high is rejected: no chip select, output enable or write enable.
- R9: If the host drops its strobes during the pulse, the write enables fall at once and no `end_cyc` follows.
- R10: While `rst_n` is low, every strobe, select and `end_cyc` output is low, with idle inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_owns | input | 1 | Arbiter grant: 1 = network controller owns the bus |
| host_sel | input | 1 | Board select from the host window decode |
| host_rd | input | 1 | Host direction, 1 = read |
| host_uds | input | 1 | Host upper byte strobe |
| host_lds | input | 1 | Host lower byte strobe |
| host_addr | input | HOST_AW | Host byte offset within the board window |
| ctl_rd | input | 1 | Controller read strobe |
| ctl_wr | input | 1 | Controller write strobe |
| ctl_addr | input | CTL_AW | Controller word address |
| mem_cs | output | NUM_BANKS | Per-bank chip select |
| mem_addr | output | WORD_AW | Word address inside a bank |
| mem_oe | output | 1 | Buffer output enable |
| mem_we_ub | output | 1 | Upper byte write enable |
| mem_we_lb | output | 1 | Lower byte write enable |
| reg_cs | output | 1 | Register port chip select |
| reg_sel_data | output | 1 | Register word select (0 = address word, 1 = data word) |
| reg_oe | output | 1 | Register read strobe |
| reg_we | output | 1 | Register write strobe |
| end_cyc | output | 1 | End of host write cycle |

## Verification
The bench keeps the defaults HOST_AW=16, BANK_BITS=1 and REG_IDX=0, and sets WR_CYCLES=3. With two banks, bit 14 splits the buffer, so the table of vectors can hit both ends of each bank and both register words. A three-cycle pulse leaves room to tell an off-by-one in the pulse counter from a correct count. It also leaves room to drop the strobes in the middle of a pulse and to take ownership away from the host while a write is pending.

// File: rtl/pkt_strobe_pkg.sv
package pkt_strobe_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_PULSE = 2'd1,
    WS_END   = 2'd2
  } wr_state_e;

  typedef struct packed {
    logic hit_mem;
    logic hit_reg;
    logic reg_word;
  } hdec_t;

endpackage

// File: rtl/pkt_host_decode.sv
module pkt_host_decode #(
  parameter int HOST_AW   = 16,
  parameter int BANK_BITS = 1,
  parameter int REG_IDX   = 0,
  localparam int WORD_AW  = HOST_AW - 2 - BANK_BITS
) (
  input  logic [HOST_AW-1:0]   addr,
  output pkt_strobe_pkg::hdec_t dec,
  output logic [BANK_BITS-1:0] bank,
  output logic [WORD_AW-1:0]   word
);
  localparam int KEY_W = HOST_AW - 3;
  localparam logic [KEY_W-1:0] REG_KEY = KEY_W'(REG_IDX);

  always_comb begin
    dec.hit_mem  = addr[HOST_AW-1];
    dec.hit_reg  = !addr[HOST_AW-1] && (addr[HOST_AW-2:2] == REG_KEY);
    dec.reg_word = addr[1];
    bank         = addr[HOST_AW-2 -: BANK_BITS];
    word         = addr[WORD_AW:1];
  end
endmodule

// File: rtl/pkt_wr_timer.sv
module pkt_wr_timer #(
  parameter int WR_CYCLES = 2,
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic preempt,
  output logic pulse,
  output logic done
);
  import pkt_strobe_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

  wr_state_e      state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      WS_IDLE: begin
        cnt_d = '0;
        if (wr_req && !preempt) state_d = WS_PULSE;
      end
      WS_PULSE: begin
        if (preempt || !wr_req) begin
          state_d = WS_IDLE;
          cnt_d   = '0;
        end else if (cnt_q == LAST) begin
          state_d = WS_END;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      WS_END: begin
        if (preempt || !wr_req) state_d = WS_IDLE;
      end
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse = (state_q == WS_PULSE) && wr_req && !preempt;
  assign done  = (state_q == WS_END) && !preempt;
endmodule

// File: rtl/pkt_lane_mux.sv
module pkt_lane_mux #(
  parameter int BANK_BITS = 1,
  parameter int WORD_AW   = 13,
  localparam int NUM_BANKS = 1 << BANK_BITS,
  localparam int CTL_AW    = WORD_AW + BANK_BITS
) (
  input  logic                   ctl_owns,
  input  logic                   host_sel,
  input  logic                   host_rd,
  input  logic                   host_uds,
  input  logic                   host_lds,
  input  pkt_strobe_pkg::hdec_t  hdec,
  input  logic [BANK_BITS-1:0]   hbank,
  input  logic [WORD_AW-1:0]     hword,
  input  logic                   pulse,
  input  logic                   ctl_rd,
  input  logic                   ctl_wr,
  input  logic [CTL_AW-1:0]      ctl_addr,
  output logic [NUM_BANKS-1:0]   mem_cs,
  output logic [WORD_AW-1:0]     mem_addr,
  output logic                   mem_oe,
  output logic                   mem_we_ub,
  output logic                   mem_we_lb,
  output logic                   reg_cs,
  output logic                   reg_sel_data,
  output logic                   reg_oe,
  output logic                   reg_we
);
  logic                 host_side, host_mem, ctl_ok, mem_act;
  logic [BANK_BITS-1:0] bank_sel;

  always_comb begin
    host_side = !ctl_owns && host_sel && (host_uds || host_lds);
    host_mem  = host_side && hdec.hit_mem;
    ctl_ok    = ctl_owns && (ctl_rd ^ ctl_wr);
    mem_act   = host_mem || ctl_ok;
    bank_sel  = ctl_owns ? ctl_addr[CTL_AW-1 -: BANK_BITS] : hbank;
    mem_addr  = ctl_owns ? ctl_addr[WORD_AW-1:0] : hword;

    mem_oe    = (host_mem && host_rd) || (ctl_ok && ctl_rd);
    mem_we_ub = (host_mem && !host_rd && pulse && host_uds) || (ctl_ok && ctl_wr);
    mem_we_lb = (host_mem && !host_rd && pulse && host_lds) || (ctl_ok && ctl_wr);

    reg_cs       = host_side && hdec.hit_reg;
    reg_sel_data = hdec.reg_word;
    reg_oe       = reg_cs && host_rd;
    reg_we       = reg_cs && !host_rd && pulse;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign mem_cs[b] = mem_act && (bank_sel == BANK_BITS'(b));
  end
endmodule

// File: rtl/pkt_mem_strobe_gen.sv
module pkt_mem_strobe_gen #(
  parameter int HOST_AW   = 16,
  parameter int BANK_BITS = 1,
  parameter int REG_IDX   = 0,
  parameter int WR_CYCLES = 2,
  localparam int NUM_BANKS = 1 << BANK_BITS,
  localparam int WORD_AW   = HOST_AW - 2 - BANK_BITS,
  localparam int CTL_AW    = WORD_AW + BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_owns,
  input  logic                 host_sel,
  input  logic                 host_rd,
  input  logic                 host_uds,
  input  logic                 host_lds,
  input  logic [HOST_AW-1:0]   host_addr,
  input  logic                 ctl_rd,
  input  logic                 ctl_wr,
  input  logic [CTL_AW-1:0]    ctl_addr,
  output logic [NUM_BANKS-1:0] mem_cs,
  output logic [WORD_AW-1:0]   mem_addr,
  output logic                 mem_oe,
  output logic                 mem_we_ub,
  output logic                 mem_we_lb,
  output logic                 reg_cs,
  output logic                 reg_sel_data,
  output logic                 reg_oe,
  output logic                 reg_we,
  output logic                 end_cyc
);
  pkt_strobe_pkg::hdec_t hdec;
  logic [BANK_BITS-1:0]  hbank;
  logic [WORD_AW-1:0]    hword;
  logic                  wr_req, pulse;

  pkt_host_decode #(
    .HOST_AW(HOST_AW), .BANK_BITS(BANK_BITS), .REG_IDX(REG_IDX)
  ) u_dec (
    .addr(host_addr), .dec(hdec), .bank(hbank), .word(hword)
  );

  assign wr_req = host_sel && !host_rd && (host_uds || host_lds);

  pkt_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .preempt(ctl_owns),
    .pulse(pulse), .done(end_cyc)
  );

  pkt_lane_mux #(.BANK_BITS(BANK_BITS), .WORD_AW(WORD_AW)) u_mux (
    .ctl_owns(ctl_owns), .host_sel(host_sel), .host_rd(host_rd),
    .host_uds(host_uds), .host_lds(host_lds), .hdec(hdec), .hbank(hbank),
    .hword(hword), .pulse(pulse), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
    .ctl_addr(ctl_addr), .mem_cs(mem_cs), .mem_addr(mem_addr),
    .mem_oe(mem_oe), .mem_we_ub(mem_we_ub), .mem_we_lb(mem_we_lb),
    .reg_cs(reg_cs), .reg_sel_data(reg_sel_data), .reg_oe(reg_oe),
    .reg_we(reg_we)
  );
endmodule

// File: rtl/pkt_mem_strobe_gen_chk.sv
module pkt_mem_strobe_gen_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_owns,
  input logic          host_sel,
  input logic          host_rd,
  input logic          host_uds,
  input logic          host_lds,
  input logic          ctl_rd,
  input logic          ctl_wr,
  input logic [NB-1:0] mem_cs,
  input logic          mem_oe,
  input logic          mem_we_ub,
  input logic          mem_we_lb,
  input logic          reg_cs,
  input logic          reg_we,
  input logic          end_cyc
);
  // R5
  cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_cs && (mem_cs != '0)) && $onehot0(mem_cs));

  // R3
  end_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_cyc |-> !(mem_we_ub || mem_we_lb || reg_we));

  // R3
  end_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_cyc) |-> $past(host_sel && !host_rd && (host_uds || host_lds)));

  // R6
  ctl_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_owns |-> !(end_cyc || reg_cs || reg_we));

  // R2
  lane_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_owns |-> ((!mem_we_ub || host_uds) && (!mem_we_lb || host_lds)));

  // R8
  ctl_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_owns && ctl_rd && ctl_wr) |-> !(mem_oe || mem_we_ub || mem_we_lb || (mem_cs != '0)));

  // R1
  oe_we_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe |-> !(mem_we_ub || mem_we_lb));
endmodule

bind pkt_mem_strobe_gen pkt_mem_strobe_gen_chk #(.NB(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_owns(ctl_owns), .host_sel(host_sel),
  .host_rd(host_rd), .host_uds(host_uds), .host_lds(host_lds),
  .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .mem_cs(mem_cs), .mem_oe(mem_oe),
  .mem_we_ub(mem_we_ub), .mem_we_lb(mem_we_lb), .reg_cs(reg_cs),
  .reg_we(reg_we), .end_cyc(end_cyc)
);

// File: tb/pkt_mem_strobe_gen_bench.sv
module pkt_mem_strobe_gen_bench;
  localparam int WRC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_owns = 1'b0, host_sel = 1'b0, host_rd = 1'b1;
  logic        host_uds = 1'b0, host_lds = 1'b0;
  logic [15:0] host_addr = '0;
  logic        ctl_rd = 1'b0, ctl_wr = 1'b0;
  logic [13:0] ctl_addr = '0;
  logic [1:0]  mem_cs;
  logic [12:0] mem_addr;
  logic        mem_oe, mem_we_ub, mem_we_lb, reg_cs, reg_sel_data;
  logic        reg_oe, reg_we, end_cyc;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pkt_mem_strobe_gen #(.WR_CYCLES(WRC)) u_pkt_mem_strobe_gen (
    .clk(clk), .rst_n(rst_n), .ctl_owns(ctl_owns), .host_sel(host_sel),
    .host_rd(host_rd), .host_uds(host_uds), .host_lds(host_lds),
    .host_addr(host_addr), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr),
    .ctl_addr(ctl_addr), .mem_cs(mem_cs), .mem_addr(mem_addr),
    .mem_oe(mem_oe), .mem_we_ub(mem_we_ub), .mem_we_lb(mem_we_lb),
    .reg_cs(reg_cs), .reg_sel_data(reg_sel_data), .reg_oe(reg_oe),
    .reg_we(reg_we), .end_cyc(end_cyc)
  );

  typedef struct packed {
    logic        ow, crd, cwr;
    logic [13:0] ca;
    logic        hs, hrd, hu, hl;
    logic [15:0] ha;
    logic [1:0]  cs;
    logic        oe, wu, wl, rcs, roe, rwe, rsd;
    logic [12:0] ma;
  } vec_t;

  // fields: owner, ctl rd, ctl wr, ctl addr, sel, rd, uds, lds, host addr |
  //         cs, oe, we_ub, we_lb, reg_cs, reg_oe, reg_we, reg_sel_data, mem_addr
  localparam vec_t TBL [13] = '{
    '{1'b0,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b1,1'b1,16'h8000, 2'b01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,13'h0000},
    '{1'b0,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b0,1'b1,16'hC006, 2'b10,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,13'h0003},
    '{1'b0,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b1,1'b0,16'hFFFE, 2'b10,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,13'h1FFF},
    '{1'b0,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b1,1'b0,16'hBFFE, 2'b01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,13'h1FFF},
    '{1'b0,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b1,1'b1,16'h0000, 2'b00,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,13'h0000},
    '{1'b0,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b1,1'b1,16'h0002, 2'b00,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,13'h0001},
    '{1'b0,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b1,1'b1,16'h0004, 2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,13'h0002},
    '{1'b0,1'b0,1'b0,14'h0000,1'b0,1'b1,1'b1,1'b1,16'h8000, 2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,13'h0000},
    '{1'b0,1'b0,1'b0,14'h0000,1'b1,1'b1,1'b0,1'b0,16'h8000, 2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,13'h0000},
    '{1'b1,1'b1,1'b0,14'h2005,1'b1,1'b1,1'b1,1'b1,16'h0000, 2'b10,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,13'h0005},
    '{1'b1,1'b0,1'b1,14'h0010,1'b0,1'b1,1'b0,1'b0,16'h0000, 2'b01,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,13'h0010},
    '{1'b1,1'b1,1'b1,14'h3FFF,1'b0,1'b1,1'b0,1'b0,16'h0000, 2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,13'h1FFF},
    '{1'b1,1'b0,1'b0,14'h2000,1'b0,1'b1,1'b0,1'b0,16'h0000, 2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,13'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] outs();
    return {mem_cs, mem_oe, mem_we_ub, mem_we_lb, reg_cs, reg_oe, reg_we, reg_sel_data, end_cyc};
  endfunction

  task automatic host_drive(input logic s, input logic rd, input logic u, input logic l,
                            input logic [15:0] a);
    host_sel = s; host_rd = rd; host_uds = u; host_lds = l; host_addr = a;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R10: outputs low in reset
    repeat (2) @(posedge clk);
    #2 check("R10 reset outputs", 32'(outs()), 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // table walk: R1 R4 R5 R7 R8 combinational cases in idle
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      ctl_owns = TBL[i].ow; ctl_rd = TBL[i].crd; ctl_wr = TBL[i].cwr; ctl_addr = TBL[i].ca;
      host_drive(TBL[i].hs, TBL[i].hrd, TBL[i].hu, TBL[i].hl, TBL[i].ha);
      #1;
      check($sformatf("R1/R4/R5/R7/R8 vec %0d strobes", i), 32'(outs()),
            32'({TBL[i].cs, TBL[i].oe, TBL[i].wu, TBL[i].wl, TBL[i].rcs, TBL[i].roe,
                 TBL[i].rwe, TBL[i].rsd, 1'b0}));
      check($sformatf("R1/R7 vec %0d mem_addr", i), 32'(mem_addr), 32'(TBL[i].ma));
    end
    @(negedge clk);
    ctl_owns = 0; ctl_rd = 0; ctl_wr = 0; host_drive(0, 1, 0, 0, 16'h0);

    // R2 R3: upper-lane write to bank 0, pulse of WRC cycles, then end_cyc
    @(negedge clk) host_drive(1, 0, 1, 0, 16'h8002);
    #1 check("R3 no pulse before edge", 32'({mem_we_ub, mem_we_lb, end_cyc}), 32'h0);
    for (int c = 0; c < WRC; c++) begin
      @(posedge clk); #2;
      check($sformatf("R2 pulse cycle %0d lanes", c), 32'({mem_cs, mem_we_ub, mem_we_lb, end_cyc}), 32'b01_1_0_0);
    end
    @(posedge clk); #2;
    check("R3 end_cyc after pulse", 32'({mem_we_ub, mem_we_lb, end_cyc}), 32'b001);
    @(posedge clk); #2;
    check("R3 end_cyc held", 32'({mem_we_ub, end_cyc}), 32'b01);
    @(negedge clk) host_drive(0, 0, 0, 0, 16'h8002);
    @(posedge clk); #2;
    check("R3 end_cyc released", 32'(end_cyc), 32'h0);

    // R2: both lanes on bank 1
    @(negedge clk) host_drive(1, 0, 1, 1, 16'hC000);
    @(posedge clk); #2;
    check("R2 both lanes bank1", 32'({mem_cs, mem_we_ub, mem_we_lb}), 32'b10_1_1);
    @(negedge clk) host_drive(1, 0, 0, 1, 16'hC000);
    #1 check("R2 lower lane only", 32'({mem_we_ub, mem_we_lb}), 32'b01);
    repeat (WRC) @(posedge clk);
    #2 check("R3 end after lane change", 32'(end_cyc), 32'h1);
    @(negedge clk) host_drive(0, 1, 0, 0, 16'h0);
    @(posedge clk);

    // R4: register data word write
    @(negedge clk) host_drive(1, 0, 0, 1, 16'h0002);
    #1 check("R4 reg_we waits for pulse", 32'({reg_cs, reg_we, reg_sel_data}), 32'b101);
    @(posedge clk); #2;
    check("R4 reg write pulse", 32'({reg_cs, reg_we, reg_sel_data, mem_we_lb, mem_cs}), 32'b1_1_1_0_00);
    repeat (WRC) @(posedge clk);
    #2 check("R4 reg write end", 32'({reg_we, end_cyc}), 32'b01);
    @(negedge clk) host_drive(0, 1, 0, 0, 16'h0);
    @(posedge clk);

    // R9: strobes dropped mid-pulse
    @(negedge clk) host_drive(1, 0, 1, 1, 16'h8010);
    @(posedge clk);
    @(negedge clk) host_drive(1, 0, 0, 0, 16'h8010);
    #1 check("R9 we falls at once", 32'({mem_we_ub, mem_we_lb}), 32'h0);
    repeat (WRC + 2) @(posedge clk);
    #2 check("R9 no end_cyc after abort", 32'(end_cyc), 32'h0);
    @(negedge clk) host_drive(0, 1, 0, 0, 16'h0);

    // R6: pending host write while controller owns the bus
    @(negedge clk) begin ctl_owns = 1; host_drive(1, 0, 1, 1, 16'h0000); end
    repeat (WRC + 3) @(posedge clk);
    #2 check("R6 host held off", 32'(outs()), 32'h0);
    @(negedge clk) ctl_owns = 0;
    @(posedge clk); #2;
    check("R6 pulse after release", 32'({reg_cs, reg_we}), 32'b11);
    @(negedge clk) ctl_owns = 1;
    #1 check("R6 pulse abandoned", 32'({reg_we, end_cyc, reg_cs}), 32'h0);
    @(posedge clk);
    @(negedge clk) ctl_owns = 0;
    @(posedge clk); #2;
    check("R6 restart from idle", 32'({reg_we, end_cyc}), 32'b10);

    // R10: reset from end state
    repeat (WRC) @(posedge clk);
    #2 check("R3 end before reset", 32'(end_cyc), 32'h1);
    @(negedge clk) rst_n = 0;
    #1 check("R10 reset clears end_cyc", 32'(end_cyc), 32'h0);
    @(negedge clk) begin host_drive(0, 1, 0, 0, 16'h0); rst_n = 1; end
    @(posedge clk); #2;
    check("R10 idle after reset", 32'(outs()), 32'h0);

    finish_run();
  end
endmodule